// File: doc/BRIEF.md
# Buffered Auto-Reload Down-Counter Bank

This block holds five 32-bit down-counting timer channels that share one control word. Software writes a count buffer and, on channels 0 to 3, a compare buffer. A channel's live counter only takes a new value from its count buffer at defined moments: a rising edge of the channel's update bit, or an expiry while auto-reload is enabled. A prescaler elsewhere supplies one tick pulse per channel. The counter steps down by one on each tick while the channel runs.

When a running channel gets a tick while its counter is already zero, the channel expires. It sends a one-cycle expiry pulse to the interrupt logic. With auto-reload set, the channel then refills from its count buffer and keeps running. Without auto-reload, the channel stops and clears its own start bit, so software can read the run state back from the control word. The register port is a simple single-cycle bus. Writes are registered. Reads are combinational from the address.

Top module: `tmr_bank`

## Requirements
- R1: After reset, the control word, every count and compare buffer, and every live counter read as zero, every channel is stopped, and no expiry pulse is present.
- R2: The control word is at byte offset 0x08. For channel c, the bits start at position 0 when c = 0 and at position 4+4c otherwise, in the order start, update, invert, reload. Channel 4 has start at bit 20, update at bit 21 and reload at bit 22, and has no invert bit. All other bits read as zero, so writing all ones reads back 0x007FFF0F.
- R3: Channel c has its count buffer at 0x0C+0x0C·c and its compare buffer at 0x10+0x0C·c for c < 4. Its observation register is at 0x14+0x0C·c, except channel 4, which uses 0x40. Buffers read back the last value written. The observation register returns the live counter. Unmapped offsets read as zero.
- R4: A 0→1 change of a channel's update bit in a control write loads that channel's count buffer into its counter at that clock edge. Writing the bit again while it is already 1 does not reload.
- R5: A 0→1 change of the start bit makes the channel run from the next cycle. A running channel decrements by one on each tick. Ticks to a stopped channel leave the counter unchanged.
- R6: A 1→0 change of the start bit stops the channel, and the counter keeps its current value.
- R7: A tick that finds a running counter at zero is an expiry. The channel's expiry output is high for exactly the one cycle after that tick's clock edge, and an expiry pulse never occurs without a tick to a running channel.
- R8: On expiry with the reload bit set, the counter is refilled from the count buffer and the start bit stays set.
- R9: On expiry with the reload bit clear, the channel clears its own start bit, the counter stays at zero, and later ticks cause no further expiry.
- R10: A single control write that raises both update and start loads the buffer first, and counting proceeds from the loaded value.
- R11: Writing a count buffer does not change the live counter until the next update edge or reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tick_i | input | 5 | One tick pulse per channel from the prescaler |
| expire_o | output | 5 | One-cycle expiry pulse per channel |

## Verification
The assertions assume that a control write never falls in the same cycle as an expiry that would clear a start bit, because the bus write takes priority there. They also assume that ticks are single-cycle pulses. The directed tasks drive ticks as isolated one-cycle pulses and leave at least one idle cycle between each bus write and the ticks that follow it. As a result, every expiry and every self-clear happens in a cycle with no control write pending.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH    = 5;
  localparam int CTRL_W = 32;
  localparam int CTRL_OFF = 8;

  // bit layout of the shared control word
  function automatic int base_pos(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int start_pos(input int ch);
    return base_pos(ch);
  endfunction

  function automatic int upd_pos(input int ch);
    return base_pos(ch) + 1;
  endfunction

  function automatic int rel_pos(input int ch);
    return (ch == NCH - 1) ? 22 : base_pos(ch) + 3;
  endfunction

  function automatic bit has_inv(input int ch);
    return ch != NCH - 1;
  endfunction

  function automatic bit has_cmp(input int ch);
    return ch != NCH - 1;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[start_pos(c)] = 1'b1;
      m[upd_pos(c)]   = 1'b1;
      if (has_inv(c)) m[base_pos(c) + 2] = 1'b1;
      m[rel_pos(c)]   = 1'b1;
    end
    return m;
  endfunction

  // register map
  function automatic int cnt_off(input int ch);
    return 12 + 12 * ch;
  endfunction

  function automatic int cmp_off(input int ch);
    return 16 + 12 * ch;
  endfunction

  function automatic int obs_off(input int ch);
    return (ch == NCH - 1) ? 64 : 20 + 12 * ch;
  endfunction
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [NCH-1:0]    hw_stop,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NCH-1:0]    run,
  output logic [NCH-1:0]    reload,
  output logic [NCH-1:0]    upd_rise,
  output logic [NCH-1:0]    start_rise,
  output logic [NCH-1:0]    start_fall
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask();

  logic [CTRL_W-1:0] stop_mask;

  for (genvar g = 0; g < NCH; g++) begin : g_bits
    localparam int SP = start_pos(g);
    localparam int UP = upd_pos(g);
    localparam int RP = rel_pos(g);
    assign run[g]        = ctrl_q[SP];
    assign reload[g]     = ctrl_q[RP];
    assign upd_rise[g]   = wr_en & wdata[UP] & ~ctrl_q[UP];
    assign start_rise[g] = wr_en & wdata[SP] & ~ctrl_q[SP];
    assign start_fall[g] = wr_en & ~wdata[SP] & ctrl_q[SP];
  end

  always_comb begin
    stop_mask = '0;
    for (int c = 0; c < NCH; c++) stop_mask[start_pos(c)] = hw_stop[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= wdata & MASK;
    else             ctrl_q <= ctrl_q & ~stop_mask;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W       = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         reload,
  input  logic         upd_rise,
  input  logic         cnt_we,
  input  logic         cmp_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cbuf_q,
  output logic [W-1:0] cmp_q,
  output logic         exp_now,
  output logic         hw_stop,
  output logic         expire_q
);
  function automatic logic [W-1:0] next_count(
    input logic [W-1:0] cur, input logic [W-1:0] buf_v,
    input logic load, input logic step, input logic expd, input logic rel);
    if (load)             return buf_v;
    if (expd)             return rel ? buf_v : cur;
    if (step)             return cur - W'(1);
    return cur;
  endfunction

  logic step_now;

  assign step_now = run & tick & ~upd_rise;
  assign exp_now  = step_now & (cnt_q == '0);
  assign hw_stop  = exp_now & ~reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cbuf_q   <= '0;
      expire_q <= 1'b0;
    end else begin
      cnt_q    <= next_count(cnt_q, cbuf_q, upd_rise, step_now, exp_now, reload);
      expire_q <= exp_now;
      if (cnt_we) cbuf_q <= wdata;
    end
  end

  if (HAS_CMP) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (cmp_we) cmp_q <= wdata;
    end
  end else begin : g_nocmp
    logic unused_cmp_we;
    assign unused_cmp_we = cmp_we;
    assign cmp_q = '0;
  end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [W-1:0]      cnt    [NCH],
  input  logic [W-1:0]      cbuf   [NCH],
  input  logic [W-1:0]      cmp    [NCH],
  output logic [CTRL_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_OFF)) rdata = ctrl_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(cnt_off(c))) rdata = CTRL_W'(cbuf[c]);
      if (has_cmp(c) && addr == ADDR_W'(cmp_off(c))) rdata = CTRL_W'(cmp[c]);
      if (addr == ADDR_W'(obs_off(c))) rdata = CTRL_W'(cnt[c]);
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    tick_i,
  output logic [NCH-1:0]    expire_o
);
  logic              ctrl_wr_w;
  logic [CTRL_W-1:0] ctrl_q_w;
  logic [NCH-1:0]    run_w, reload_w, upd_rise_w, start_rise_w, start_fall_w;
  logic [NCH-1:0]    exp_now_w, hw_stop_w;
  logic [CNT_W-1:0]  cnt_w  [NCH];
  logic [CNT_W-1:0]  cbuf_w [NCH];
  logic [CNT_W-1:0]  cmp_w  [NCH];

  assign ctrl_wr_w = bus_wr & (bus_addr == ADDR_W'(CTRL_OFF));

  tmr_ctrl_reg ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ctrl_wr_w),
    .wdata      (bus_wdata),
    .hw_stop    (hw_stop_w),
    .ctrl_q     (ctrl_q_w),
    .run        (run_w),
    .reload     (reload_w),
    .upd_rise   (upd_rise_w),
    .start_rise (start_rise_w),
    .start_fall (start_fall_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cnt_we, cmp_we;
    assign cnt_we = bus_wr & (bus_addr == ADDR_W'(cnt_off(g)));
    assign cmp_we = bus_wr & has_cmp(g) & (bus_addr == ADDR_W'(cmp_off(g)));

    tmr_channel #(.W(CNT_W), .HAS_CMP(has_cmp(g))) ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_i[g]),
      .run      (run_w[g]),
      .reload   (reload_w[g]),
      .upd_rise (upd_rise_w[g]),
      .cnt_we   (cnt_we),
      .cmp_we   (cmp_we),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .cnt_q    (cnt_w[g]),
      .cbuf_q   (cbuf_w[g]),
      .cmp_q    (cmp_w[g]),
      .exp_now  (exp_now_w[g]),
      .hw_stop  (hw_stop_w[g]),
      .expire_q (expire_o[g])
    );
  end

  tmr_rdmux #(.W(CNT_W), .ADDR_W(ADDR_W)) rd_i (
    .addr   (bus_addr),
    .ctrl_q (ctrl_q_w),
    .cnt    (cnt_w),
    .cbuf   (cbuf_w),
    .cmp    (cmp_w),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tick,
  input logic [NCH-1:0] run,
  input logic [NCH-1:0] reload,
  input logic [NCH-1:0] upd_rise,
  input logic [NCH-1:0] start_fall,
  input logic [NCH-1:0] exp_now,
  input logic           ctrl_wr,
  input logic [NCH-1:0] expire,
  input logic [W-1:0]   cnt  [NCH],
  input logic [W-1:0]   cbuf [NCH]
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    // R4
    upd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_rise[g] |=> cnt[g] == $past(cbuf[g]));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[g] && !upd_rise[g]) |=> $stable(cnt[g]));

    // R6
    fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_fall[g] && !upd_rise[g]) |=> (cnt[g] == $past(cnt[g]) || $past(tick[g])));

    // R5
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && tick[g] && !upd_rise[g] && cnt[g] != '0) |=> cnt[g] == $past(cnt[g]) - W'(1));

    // R7
    exp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |-> $past(run[g] && tick[g]));

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_now[g] && reload[g] && !ctrl_wr) |=> (cnt[g] == $past(cbuf[g]) && run[g]));

    // R9
    self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_now[g] && !reload[g] && !ctrl_wr) |=> (!run[g] && cnt[g] == '0));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick_i),
  .run        (run_w),
  .reload     (reload_w),
  .upd_rise   (upd_rise_w),
  .start_fall (start_fall_w),
  .exp_now    (exp_now_w),
  .ctrl_wr    (ctrl_wr_w),
  .expire     (expire_o),
  .cnt        (cnt_w),
  .cbuf       (cbuf_w)
);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick_i = '0;
  logic [4:0]  expire_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tmr_bank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_i    (tick_i),
    .expire_o  (expire_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tk(input logic [4:0] m, output logic [4:0] e);
    @(negedge clk);
    tick_i = m;
    @(negedge clk);
    tick_i = '0;
    #1 e = expire_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h08, d); check("R1 ctrl", d, 0);
    rd(8'h0C, d); check("R1 count buffer", d, 0);
    rd(8'h10, d); check("R1 compare buffer", d, 0);
    rd(8'h14, d); check("R1 counter", d, 0);
    check("R1 expire", {27'd0, expire_o}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int c = 0; c < 5; c++) wr(8'(12 + 12 * c), 32'h11 * (c + 1));
    for (int c = 0; c < 4; c++) wr(8'(16 + 12 * c), 32'hA0 + c);
    for (int c = 0; c < 5; c++) begin
      rd(8'(12 + 12 * c), d); check("R3 count buffer readback", d, 32'h11 * (c + 1));
    end
    for (int c = 0; c < 4; c++) begin
      rd(8'(16 + 12 * c), d); check("R3 compare buffer readback", d, 32'hA0 + c);
    end
    rd(8'h40, d); check("R3 R11 ch4 observation unchanged", d, 0);
    rd(8'h4C, d); check("R3 unmapped", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R2 ctrl mask", d, 32'h007F_FF0F);
    rd(8'h14, d); check("R4 ch0 loaded", d, 32'h11);
    rd(8'h40, d); check("R3 R4 ch4 observation loaded", d, 32'h55);
    wr(8'h08, 0);
    rd(8'h08, d); check("R2 ctrl cleared", d, 0);
  endtask

  task automatic t_update();
    logic [31:0] d;
    wr(8'h0C, 5);
    wr(8'h08, 32'h2);
    rd(8'h14, d); check("R4 update edge load", d, 5);
    wr(8'h0C, 9);
    rd(8'h14, d); check("R11 buffer write no effect", d, 5);
    wr(8'h08, 32'h2);
    rd(8'h14, d); check("R4 held bit no reload", d, 5);
    wr(8'h08, 0);
    wr(8'h08, 32'h2);
    rd(8'h14, d); check("R4 second edge load", d, 9);
  endtask

  task automatic t_run();
    logic [31:0] d; logic [4:0] e;
    wr(8'h08, 0);
    tk(5'h1, e); tk(5'h1, e);
    rd(8'h14, d); check("R5 ticks while stopped ignored", d, 9);
    wr(8'h08, 32'h1);
    @(negedge clk);
    for (int i = 0; i < 3; i++) tk(5'h1, e);
    rd(8'h14, d); check("R5 three ticks decrement", d, 6);
    wr(8'h08, 0);
    @(negedge clk);
    tk(5'h1, e); tk(5'h1, e);
    rd(8'h14, d); check("R6 stop holds count", d, 6);
  endtask

  task automatic t_reload();
    logic [31:0] d; logic [4:0] e;
    wr(8'h08, 32'h9);
    @(negedge clk);
    for (int i = 0; i < 6; i++) tk(5'h1, e);
    check("R7 no expiry before zero", {27'd0, e}, 0);
    rd(8'h14, d); check("R5 counted to zero", d, 0);
    tk(5'h1, e);
    check("R7 expiry pulse", {27'd0, e}, 32'h1);
    @(negedge clk); #1;
    check("R7 pulse one cycle", {27'd0, expire_o}, 0);
    rd(8'h14, d); check("R8 reloaded", d, 9);
    rd(8'h08, d); check("R8 still running", d, 32'h9);
    tk(5'h1, e);
    rd(8'h14, d); check("R8 keeps counting", d, 8);
  endtask

  task automatic t_oneshot();
    logic [31:0] d; logic [4:0] e;
    wr(8'h18, 2);
    wr(8'h08, 32'h300);
    @(negedge clk);
    rd(8'h20, d); check("R10 load before count", d, 2);
    tk(5'h2, e);
    rd(8'h20, d); check("R10 counts from loaded", d, 1);
    tk(5'h2, e);
    tk(5'h2, e);
    check("R7 ch1 expiry", {27'd0, e}, 32'h2);
    @(negedge clk);
    rd(8'h08, d); check("R9 start bit self-cleared", d, 32'h200);
    rd(8'h20, d); check("R9 counter stays zero", d, 0);
    tk(5'h2, e);
    check("R9 no further expiry", {27'd0, e}, 0);
  endtask

  task automatic t_ch4();
    logic [31:0] d; logic [4:0] e;
    wr(8'h3C, 1);
    wr(8'h08, 32'h0070_0000);
    @(negedge clk);
    tk(5'h10, e);
    check("R7 ch4 no early expiry", {27'd0, e}, 0);
    tk(5'h10, e);
    check("R2 R8 ch4 expiry", {27'd0, e}, 32'h10);
    @(negedge clk);
    rd(8'h40, d); check("R2 R8 ch4 reload via bit 22", d, 1);
    rd(8'h08, d); check("R2 R8 ch4 still running", d, 32'h0070_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_ctrl();
    t_update();
    t_run();
    t_reload();
    t_oneshot();
    t_ch4();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule